// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt requests and presents them to a processor as two outputs: a normal interrupt line and a fast interrupt line. Each source has an enable bit, a software trigger bit and a route bit, and each is controlled through a small synchronous register port. A source counts as pending when its hardware input is high or its software trigger is set. A pending source with its enable bit set is then steered to one of the two outputs by its route bit.

Sixteen vector slots each bind one source to a handler address. The slots are ranked by index, and slot 0 has the highest priority. When software reads the vector register it gets the handler address of the best pending slot, or a programmable fallback address when no slot matches. That read puts the slot in service, which holds back the slot and every slot of lower priority. Any write to the same register retires the most urgent slot in service, so nested handlers unwind in order. A protection bit can block unprivileged writes. Four identification words can be read back.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, irq_o and fiq_o are low and the enable, soft, route, protect, fallback and slot registers all read 0.
- R2: Writing to 0x010 sets every enable bit whose data bit is 1, and writing to 0x014 clears every enable bit whose data bit is 1. Zero bits leave the state unchanged. A read of 0x010 returns the enable mask.
- R3: Soft triggers use the same scheme, with 0x018 to set (readable) and 0x01C to clear. A soft bit asserts source n just as a high input would. Raw status at 0x008 reads irq_src OR soft.
- R4: The route register at 0x00C sends source n to the fast line when bit n is 1 and to the normal line when it is 0. Status at 0x000 is enabled, pending and normal-routed; status at 0x004 is enabled, pending and fast-routed. irq_o and fiq_o are the OR of the matching status, one clock later.
- R5: Slot i has a handler address register at 0x100+4i and a control register at 0x200+4i. In the control register, bit 5 is the enable and bits 4:0 are the source index. Both registers read back.
- R6: A read of 0x030 returns the handler address of the lowest-index enabled slot whose source is set in the normal-line status. When there is no such slot, it returns the fallback address at 0x034.
- R7: A read of 0x030 that returns a slot's address marks that slot in service. While a slot is in service, it and all higher-index slots are excluded from R6, and lower-index slots can still win.
- R8: A write of any value to 0x030 retires the lowest-index slot in service. Repeated writes unwind the nesting, and a write when no slot is in service has no effect.
- R9: The protect bit is bit 0 of 0x020. While it is 1, writes with bus_priv low are ignored at every address, and writes with bus_priv high still take effect.
- R10: A read of 0xFE0+4k returns byte k of the ID word in bits 7:0 and zeros above. The default ID word is 0x0A141190, so the vendor field in bits 19:12 is 0x41.
- R11: Read data appears on bus_rdata on the clock after the request, and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NSRC | Level-sensitive hardware requests |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read |
| irq_o | output | 1 | Normal interrupt line (registered) |
| fiq_o | output | 1 | Fast interrupt line (registered) |

## Verification
The bench walks a soft trigger across every source under a mixed route mask. A design that swapped the route sense, or dropped the soft term from the raw status, would light the wrong line. A priority sweep adds pending slots from the lowest priority upward and expects the newest slot to win each time; an encoder that picked the highest index would return stale addresses. A nesting sequence checks three things: a pending slot behind an in-service slot must yield the fallback address, a more urgent slot must still preempt, and each acknowledge must retire only the most urgent in-service slot. A design that cleared the whole in-service set would return a handler where the fallback is expected. Protection, disabled slots, fast-routed sources and the identification bytes are each checked at the ports.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [3:0] {
    RS_IRQST, RS_FIQST, RS_RAW, RS_SEL, RS_ENSET, RS_ENCLR, RS_SWSET,
    RS_SWCLR, RS_PROT, RS_VEC, RS_DEF, RS_SLOTADR, RS_SLOTCTL, RS_ID, RS_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a[11:8] == 4'h1) return RS_SLOTADR;
    if (a[11:8] == 4'h2) return RS_SLOTCTL;
    if (a[11:4] == 8'hFE) return RS_ID;
    case (a)
      12'h000: return RS_IRQST;
      12'h004: return RS_FIQST;
      12'h008: return RS_RAW;
      12'h00C: return RS_SEL;
      12'h010: return RS_ENSET;
      12'h014: return RS_ENCLR;
      12'h018: return RS_SWSET;
      12'h01C: return RS_SWCLR;
      12'h020: return RS_PROT;
      12'h030: return RS_VEC;
      12'h034: return RS_DEF;
      default: return RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] hw_irq,
  input  logic            en_set,
  input  logic            en_clr,
  input  logic            sw_set,
  input  logic            sw_clr,
  input  logic            sel_wr,
  input  logic [NSRC-1:0] wval,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] sw_q,
  output logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  logic [NSRC-1:0] live;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sw_q  <= '0;
      sel_q <= '0;
    end else begin
      if (en_set) en_q <= en_q | wval;
      if (en_clr) en_q <= en_q & ~wval;
      if (sw_set) sw_q <= sw_q | wval;
      if (sw_clr) sw_q <= sw_q & ~wval;
      if (sel_wr) sel_q <= wval;
    end
  end

  always_comb begin
    raw      = hw_irq | sw_q;
    live     = raw & en_q;
    irq_stat = live & ~sel_q;
    fiq_stat = live & sel_q;
  end
endmodule

// File: rtl/vic_slot_arb.sv
module vic_slot_arb #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  localparam int SW   = $clog2(NSRC),
  localparam int IW   = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_stat,
  input  logic             ctl_we,
  input  logic             adr_we,
  input  logic [IW-1:0]    widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IW-1:0]    ridx,
  input  logic             take,
  input  logic             ack,
  input  logic [DW-1:0]    def_vec,
  output logic [SW:0]      ctl_rd,
  output logic [DW-1:0]    adr_rd,
  output logic [DW-1:0]    cur_vec,
  output logic             cur_hit,
  output logic [NSLOT-1:0] in_svc
);
  logic [SW:0]      ctl_q [NSLOT];
  logic [DW-1:0]    adr_q [NSLOT];
  logic [NSLOT-1:0] hit, allowed, cand;
  logic [IW-1:0]    win;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSLOT; s++) begin
        ctl_q[s] <= '0;
        adr_q[s] <= '0;
      end
    end else begin
      if (ctl_we) ctl_q[widx] <= wdata[SW:0];
      if (adr_we) adr_q[widx] <= wdata;
    end
  end

  assign ctl_rd = ctl_q[ridx];
  assign adr_rd = adr_q[ridx];

  for (genvar s = 0; s < NSLOT; s++) begin : g_hit
    assign hit[s] = ctl_q[s][SW] & irq_stat[ctl_q[s][SW-1:0]];
  end

  // a slot in service shadows itself and every later slot
  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      blk        = blk | in_svc[s];
      allowed[s] = ~blk;
    end
    cand    = hit & allowed;
    win     = '0;
    cur_hit = 1'b0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (cand[s]) begin
        win     = IW'(s);
        cur_hit = 1'b1;
      end
    end
    cur_vec = cur_hit ? adr_q[win] : def_vec;
  end

  always_ff @(posedge clk) begin
    if (rst)                 in_svc <= '0;
    else if (take && cur_hit) in_svc <= in_svc | (NSLOT'(1) << win);
    else if (ack)            in_svc <= in_svc & (in_svc - 1'b1);
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int          NSRC    = 32,
  parameter int          NSLOT   = 16,
  parameter int          DW      = 32,
  parameter logic [31:0] ID_WORD = 32'h0A14_1190
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int SW = $clog2(NSRC);
  localparam int IW = $clog2(NSLOT);

  reg_sel_e         rsel;
  logic             wr_ok, rd_go;
  logic             prot_q;
  logic [DW-1:0]    def_q;
  logic [NSRC-1:0]  en_q, sw_q, sel_q, raw, irq_stat, fiq_stat;
  logic [SW:0]      ctl_rd;
  logic [DW-1:0]    adr_rd, cur_vec, rd_mux;
  logic             cur_hit;
  logic [NSLOT-1:0] svc_mask;
  logic [IW-1:0]    sidx;

  assign rsel  = decode(bus_addr);
  assign wr_ok = bus_en && bus_we && (!prot_q || bus_priv);
  assign rd_go = bus_en && !bus_we;
  assign sidx  = bus_addr[IW+1:2];

  vic_src_bank #(.NSRC(NSRC)) u_src (
    .clk(clk), .rst(rst), .hw_irq(irq_src),
    .en_set(wr_ok && rsel == RS_ENSET), .en_clr(wr_ok && rsel == RS_ENCLR),
    .sw_set(wr_ok && rsel == RS_SWSET), .sw_clr(wr_ok && rsel == RS_SWCLR),
    .sel_wr(wr_ok && rsel == RS_SEL), .wval(bus_wdata[NSRC-1:0]),
    .en_q(en_q), .sw_q(sw_q), .sel_q(sel_q), .raw(raw),
    .irq_stat(irq_stat), .fiq_stat(fiq_stat)
  );

  vic_slot_arb #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .irq_stat(irq_stat),
    .ctl_we(wr_ok && rsel == RS_SLOTCTL), .adr_we(wr_ok && rsel == RS_SLOTADR),
    .widx(sidx), .wdata(bus_wdata), .ridx(sidx),
    .take(rd_go && rsel == RS_VEC), .ack(wr_ok && rsel == RS_VEC),
    .def_vec(def_q), .ctl_rd(ctl_rd), .adr_rd(adr_rd),
    .cur_vec(cur_vec), .cur_hit(cur_hit), .in_svc(svc_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= 1'b0;
      def_q  <= '0;
    end else if (wr_ok) begin
      if (rsel == RS_PROT) prot_q <= bus_wdata[0];
      if (rsel == RS_DEF)  def_q  <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (rsel)
      RS_IRQST:   rd_mux = DW'(irq_stat);
      RS_FIQST:   rd_mux = DW'(fiq_stat);
      RS_RAW:     rd_mux = DW'(raw);
      RS_SEL:     rd_mux = DW'(sel_q);
      RS_ENSET:   rd_mux = DW'(en_q);
      RS_SWSET:   rd_mux = DW'(sw_q);
      RS_PROT:    rd_mux = DW'(prot_q);
      RS_VEC:     rd_mux = cur_vec;
      RS_DEF:     rd_mux = def_q;
      RS_SLOTADR: rd_mux = adr_rd;
      RS_SLOTCTL: rd_mux = DW'(ctl_rd);
      RS_ID:      rd_mux = DW'(ID_WORD[8*bus_addr[3:2] +: 8]);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      if (rd_go) bus_rdata <= rd_mux;
      irq_o <= |irq_stat;
      fiq_o <= |fiq_stat;
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_en,
  input logic             bus_we,
  input logic             bus_priv,
  input logic [11:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             prot_q,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  irq_stat,
  input logic [NSRC-1:0]  fiq_stat,
  input logic [NSLOT-1:0] svc_mask,
  input logic             cur_hit
);
  logic wr_ok;
  assign wr_ok = bus_en && bus_we && (!prot_q || bus_priv);

  a_r4_irq_line: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|irq_stat));

  a_r4_fiq_line: assert property (@(posedge clk) disable iff (rst)
    fiq_o == $past(|fiq_stat));

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && bus_addr == 12'h010) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  a_r9_locked_out: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && prot_q && !bus_priv) |=> $stable(en_q));

  a_r8_one_unwind: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && bus_addr == 12'h030 && svc_mask != '0) |=>
      ($countones(svc_mask) == $countones($past(svc_mask)) - 1));

  a_r7_miss_no_take: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr == 12'h030 && !cur_hit) |=> $stable(svc_mask));
endmodule

bind vic_ctrl vic_checker #(.NSRC(NSRC), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_priv(bus_priv),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o), .fiq_o(fiq_o),
  .prot_q(prot_q), .en_q(en_q), .irq_stat(irq_stat), .fiq_stat(fiq_stat),
  .svc_mask(svc_mask), .cur_hit(cur_hit)
);

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
  localparam logic [11:0] A_IRQ = 12'h000, A_FIQ = 12'h004, A_RAW = 12'h008,
    A_SEL = 12'h00C, A_ENS = 12'h010, A_ENC = 12'h014, A_SWS = 12'h018,
    A_SWC = 12'h01C, A_PROT = 12'h020, A_VEC = 12'h030, A_DEF = 12'h034;
  localparam logic [31:0] DEFV = 32'h0000_0FF0;

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] irq_src = '0;
  logic bus_en = 0, bus_we = 0, bus_priv = 1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, fiq_o;
  int n_cmp = 0, n_bad = 0;

  vic_ctrl uut (.clk(clk), .rst(rst), .irq_src(irq_src), .bus_en(bus_en),
    .bus_we(bus_we), .bus_priv(bus_priv), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  always #4 clk = ~clk;

  function automatic logic [31:0] hadr(int i);
    return 32'h0000_8000 + 32'(i) * 32'h40;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic p = 1'b1);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_priv = p;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_priv = 1;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, input logic p = 1'b1);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_priv = p;
    @(negedge clk);
    bus_en = 0; bus_priv = 1;
    d = bus_rdata;
  endtask

  task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, exp_en, id;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq_o", {31'b0, irq_o}, 0);
    chk("R1 fiq_o", {31'b0, fiq_o}, 0);
    rchk("R1 enable", A_ENS, 0);
    rchk("R1 soft", A_SWS, 0);
    rchk("R1 route", A_SEL, 0);
    rchk("R1 protect", A_PROT, 0);
    rchk("R1 fallback", A_DEF, 0);
    rchk("R1 slot ctl", 12'h200, 0);

    // R2 write-one-to-set / clear sweep
    exp_en = 0;
    for (int n = 0; n < 32; n++) begin
      wr(A_ENS, 32'(1) << n);
      exp_en |= 32'(1) << n;
      rchk("R2 set sweep", A_ENS, exp_en);
    end
    wr(A_ENC, 32'h5555_5555);
    rchk("R2 clear even", A_ENS, 32'hAAAA_AAAA);
    wr(A_ENC, 32'h0);
    rchk("R2 zero clear no effect", A_ENS, 32'hAAAA_AAAA);
    wr(A_ENS, 32'hFFFF_FFFF);

    // R3 / R4 soft sweep under mixed routing
    wr(A_SEL, 32'hF0F0_F0F0);
    for (int n = 0; n < 32; n++) begin
      logic f;
      f = ((n >> 2) & 1) == 1;
      wr(A_SWS, 32'(1) << n);
      @(negedge clk);
      chk("R4 irq_o", {31'b0, irq_o}, {31'b0, !f});
      chk("R4 fiq_o", {31'b0, fiq_o}, {31'b0, f});
      rchk("R3 raw", A_RAW, 32'(1) << n);
      rchk("R4 irq status", A_IRQ, f ? 0 : 32'(1) << n);
      rchk("R4 fiq status", A_FIQ, f ? 32'(1) << n : 0);
      wr(A_SWC, 32'(1) << n);
      rchk("R3 soft clear", A_SWS, 0);
    end
    wr(A_SEL, 0);
    // R3 hardware levels through enable mask
    wr(A_ENC, 32'hFFFF_FFCF);
    irq_src = 32'h0000_00F0;
    @(negedge clk); @(negedge clk);
    chk("R4 hw irq_o", {31'b0, irq_o}, 1);
    rchk("R3 hw raw", A_RAW, 32'h0000_00F0);
    rchk("R4 hw masked status", A_IRQ, 32'h0000_0030);
    irq_src = 0;
    wr(A_ENS, 32'hFFFF_FFFF);

    // R5 slot programming
    for (int i = 0; i < 16; i++) begin
      wr(12'h100 + 12'(4 * i), hadr(i));
      wr(12'h200 + 12'(4 * i), 32'h20 | 32'(2 * i));
    end
    wr(A_DEF, DEFV);
    rchk("R5 slot ctl readback", 12'h21C, 32'h2E);
    rchk("R5 slot adr readback", 12'h11C, hadr(7));
    rchk("R6 nothing pending", A_VEC, DEFV);

    // R6 priority sweep: add slots from low priority upward
    for (int i = 15; i >= 0; i--) begin
      wr(A_SWS, 32'(1) << (2 * i));
      rchk("R6 lowest index wins", A_VEC, hadr(i));
      wr(A_VEC, 0);
    end
    wr(A_SWC, 32'hFFFF_FFFF);

    // R6 disabled slot and fast-routed source
    wr(12'h20C, 32'h6);
    wr(A_SWS, 32'h40);
    rchk("R6 disabled slot ignored", A_VEC, DEFV);
    wr(12'h20C, 32'h26);
    wr(A_SWC, 32'h40);
    wr(A_SEL, 32'h400);
    wr(A_SWS, 32'h400);
    rchk("R6 fast-routed ignored", A_VEC, DEFV);
    wr(A_SWC, 32'h400);
    wr(A_SEL, 0);

    // R7 / R8 nesting
    wr(A_SWS, (32'(1) << 10) | (32'(1) << 18));
    rchk("R7 first take", A_VEC, hadr(5));
    rchk("R7 in service shadows", A_VEC, DEFV);
    wr(A_SWS, 32'(1) << 4);
    rchk("R7 preempt by higher", A_VEC, hadr(2));
    wr(A_SWC, 32'(1) << 4);
    wr(A_VEC, 0);
    rchk("R8 outer still in service", A_VEC, DEFV);
    wr(A_VEC, 32'h1234);
    rchk("R8 unwound", A_VEC, hadr(5));
    wr(A_VEC, 0);
    wr(A_SWC, 32'hFFFF_FFFF);
    wr(A_VEC, 0);
    wr(A_SWS, 32'(1) << 18);
    rchk("R8 empty ack harmless", A_VEC, hadr(9));
    wr(A_VEC, 0);
    wr(A_SWC, 32'hFFFF_FFFF);

    // R9 protection
    wr(A_ENC, 32'hFFFF_FFFF);
    wr(A_PROT, 1);
    wr(A_ENS, 32'h0000_FFFF, 1'b0);
    rchk("R9 unpriv write ignored", A_ENS, 0);
    wr(A_PROT, 0, 1'b0);
    rd(A_PROT, d, 1'b0);
    chk("R9 unpriv protect clear ignored", d, 1);
    wr(A_ENS, 32'h0000_00FF, 1'b1);
    rchk("R9 priv write", A_ENS, 32'h0000_00FF);
    wr(A_PROT, 0);
    wr(A_ENS, 32'h0000_FF00, 1'b0);
    rchk("R9 unlocked", A_ENS, 32'h0000_FFFF);

    // R10 identification bytes
    id = 0;
    for (int k = 0; k < 4; k++) begin
      rd(12'hFE0 + 12'(4 * k), d);
      chk("R10 upper zero", d & 32'hFFFF_FF00, 0);
      id |= (d & 32'hFF) << (8 * k);
    end
    chk("R10 id word", id, 32'h0A14_1190);
    chk("R10 vendor", (id >> 12) & 32'hFF, 32'h41);

    // R11 unmapped and latency
    rchk("R11 unmapped", 12'h040, 0);
    rchk("R11 latency", A_ENS, 32'h0000_FFFF);

    finish_run();
  end
endmodule